// File: doc/BRIEF.md
# Microprogram Sequencer with Invertible Branch

This block produces the microinstruction address for a microcoded processor, one new address per machine cycle. The address register is built from cascaded 4-bit loadable counter slices: each cycle the whole register either steps to the next address, with carries rippling between slices, or loads the target field of the current microword when a branch is taken.

The branch decision picks a status signal with a 4-bit condition code, then passes it through an XOR with a single invert bit in the microword. Any test can therefore branch on either sense, so a branch on a non-zero result fits in one microword. Two (code, invert) pairs never branch and mark a microword as a plain ALU operation. When such an ALU microword sources the UART data register on the B bus, the block raises a one-cycle pulse that clears the UART's received-data flag. Branch microwords that happen to carry the same B-bus field leave that flag alone.

Top module: `useq_top`

## Requirements
- R1: While the synchronous reset `rst` is high at a rising clock edge, `uaddr` becomes 000 and `uart_drr` becomes 0 after that edge.
- R2: When the branch is not taken, `uaddr` becomes the previous address plus one after the edge. Carries pass between the 4-bit slices, and FFF wraps to 000.
- R3: When the branch is taken, `uaddr` becomes `mw_target` after the edge.
- R4: The branch is taken when the selected condition XOR `mw_inv` is 1. Code 0 selects constant 0 and code 7 selects constant 1. Codes 1 to 6 select `status[code-1]`, and codes 8 to 15 select `status[code-2]`. Code 1 is the ALU zero flag, `status[0]`.
- R5: A microword with code 0000 and `mw_inv`=0, or code 0111 and `mw_inv`=1, is an ALU operation and never branches.
- R6: After an edge that samples an ALU-operation microword with `mw_bsrc`=3, `uart_drr` is 1 for the following cycle.
- R7: After an edge that samples any other microword, `uart_drr` is 0. This covers a branch microword with `mw_bsrc`=3 and an ALU microword with another source, so each qualifying microword gives exactly one cycle of pulse.
- R8: Code 1 with `mw_inv`=1 branches exactly when the zero flag is 0. Code 0 with `mw_inv`=1, and code 7 with `mw_inv`=0, always branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Machine clock |
| rst | input | 1 | Synchronous reset, active high |
| mw_cond | input | 4 | Condition-select field of the current microword |
| mw_inv | input | 1 | Condition invert bit |
| mw_target | input | 12 | Branch target field |
| mw_bsrc | input | 3 | B-bus source register field |
| status | input | 14 | Status inputs; bit 0 is the ALU zero flag |
| uaddr | output | 12 | Current microinstruction address |
| uart_drr | output | 1 | One-cycle reset of the UART data-ready flag |

## Verification
The bench aims at the two ALU-operation encodings and their mirror codes. If a design ignored the invert bit when it recognized ALU operations, code 0000 with the invert bit set would never branch, and code 0111 with it clear would pulse the UART. Directed runs step across 0FF to 100 and across FFF to 000. A slice that drops its carry or that fails to wrap shows up there as a wrong address. Random microwords give a high share of source register 3, so a pulse that leaks from branch microwords or that stretches over two cycles shows up against the bench model.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int NSTAT     = 14;
  localparam int CODE_W    = 4;
  localparam logic [CODE_W-1:0] CODE_FALSE = 4'd0;
  localparam logic [CODE_W-1:0] CODE_TRUE  = 4'd7;

  // Picks the raw condition for a code: 0 is false, 7 is true, the rest map to status bits.
  function automatic logic useq_cond_pick(input logic [CODE_W-1:0] code,
                                          input logic [NSTAT-1:0]  stat);
    logic r;
    r = 1'b0;
    for (int i = 1; i < 16; i++) begin
      if (code == CODE_W'(i)) begin
        if (i == 7)      r = 1'b1;
        else if (i < 7)  r = stat[i-1];
        else             r = stat[i-2];
      end
    end
    return r;
  endfunction

  // A microword that can never branch is a plain ALU operation.
  function automatic logic useq_is_alu(input logic [CODE_W-1:0] code, input logic inv);
    return (code == CODE_FALSE && !inv) || (code == CODE_TRUE && inv);
  endfunction
endpackage

// File: rtl/useq_nibble_ctr.sv
module useq_nibble_ctr #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         cin,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         cout
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
    else if (cin)  q <= q + 1'b1;
  end

  assign cout = cin && (q == {W{1'b1}});

  // R2: a full slice with carry in rolls over to zero
  p_slice_roll_r2: assert property (@(posedge clk) disable iff (rst)
    (!load && cin && q == {W{1'b1}}) |=> (q == '0));
endmodule

// File: rtl/useq_cond_sel.sv
module useq_cond_sel
  import useq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] code,
  input  logic              inv,
  input  logic [NSTAT-1:0]  stat,
  output logic              cond_raw,
  output logic              take
);
  assign cond_raw = useq_cond_pick(code, stat);
  assign take     = cond_raw ^ inv;

  // R8: branch-if-nonzero is taken whenever the zero flag is clear
  p_nonzero_r8: assert property (@(posedge clk) disable iff (rst)
    (code == 4'd1 && inv && !stat[0]) |-> take);
  // R8: inverted "never" always branches
  p_inv_never_r8: assert property (@(posedge clk) disable iff (rst)
    (code == CODE_FALSE && inv) |-> take);
endmodule

// File: rtl/useq_alu_decode.sv
module useq_alu_decode
  import useq_pkg::*;
#(
  parameter int BW      = 3,
  parameter int DRR_REG = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] code,
  input  logic              inv,
  input  logic [BW-1:0]     bsrc,
  output logic              alu_op,
  output logic              drr
);
  logic drr_hit;

  assign alu_op  = useq_is_alu(code, inv);
  assign drr_hit = alu_op && (bsrc == BW'(DRR_REG));

  always_ff @(posedge clk) begin
    if (rst) drr <= 1'b0;
    else     drr <= drr_hit;
  end

  // R6: an ALU microword reading the UART register yields the pulse
  p_drr_set_r6: assert property (@(posedge clk) disable iff (rst)
    (alu_op && bsrc == BW'(DRR_REG)) |=> drr);
  // R7: a branch microword never yields the pulse
  p_drr_branch_r7: assert property (@(posedge clk) disable iff (rst)
    (!alu_op) |=> !drr);
endmodule

// File: rtl/useq_top.sv
module useq_top
  import useq_pkg::*;
#(
  parameter int NIB     = 3,
  parameter int BW      = 3,
  parameter int DRR_REG = 3,
  localparam int SW     = 4,
  localparam int AW     = NIB * SW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] mw_cond,
  input  logic              mw_inv,
  input  logic [AW-1:0]     mw_target,
  input  logic [BW-1:0]     mw_bsrc,
  input  logic [NSTAT-1:0]  status,
  output logic [AW-1:0]     uaddr,
  output logic              uart_drr
);
  logic           take;
  logic           cond_raw;
  logic           alu_op;
  logic [NIB:0]   carry;

  useq_cond_sel u_cond (
    .clk(clk), .rst(rst), .code(mw_cond), .inv(mw_inv), .stat(status),
    .cond_raw(cond_raw), .take(take)
  );

  useq_alu_decode #(.BW(BW), .DRR_REG(DRR_REG)) u_dec (
    .clk(clk), .rst(rst), .code(mw_cond), .inv(mw_inv), .bsrc(mw_bsrc),
    .alu_op(alu_op), .drr(uart_drr)
  );

  assign carry[0] = 1'b1;

  for (genvar g = 0; g < NIB; g++) begin : g_slice
    useq_nibble_ctr #(.W(SW)) u_ctr (
      .clk(clk), .rst(rst), .load(take), .cin(carry[g]),
      .d(mw_target[g*SW +: SW]), .q(uaddr[g*SW +: SW]), .cout(carry[g+1])
    );
  end

  // R1: reset clears the address
  p_reset_r1: assert property (@(posedge clk) rst |=> (uaddr == '0 && !uart_drr));
  // R2: no branch means step by one
  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    !take |=> (uaddr == AW'($past(uaddr) + 1'b1)));
  // R3: a taken branch loads the target
  p_load_r3: assert property (@(posedge clk) disable iff (rst)
    take |=> (uaddr == $past(mw_target)));
  // R5: ALU microwords never branch
  p_alu_nobranch_r5: assert property (@(posedge clk) disable iff (rst)
    alu_op |-> !take);
  // R4: the raw condition and the invert bit together decide the branch
  p_xor_r4: assert property (@(posedge clk) disable iff (rst)
    (cond_raw != mw_inv) |-> take);
endmodule

// File: tb/sim_useq_top.sv
module sim_useq_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  mw_cond;
  logic        mw_inv;
  logic [11:0] mw_target;
  logic [2:0]  mw_bsrc;
  logic [13:0] status;
  logic [11:0] uaddr;
  logic        uart_drr;

  int n_chk  = 0;
  int n_fail = 0;
  logic [11:0] e_pc;
  logic        e_drr;
  bit          done = 0;

  always #10 clk = ~clk;

  useq_top u0 (.*);

  function automatic logic m_cond(input logic [3:0] c, input logic [13:0] s);
    case (c)
      4'd0: return 1'b0;
      4'd7: return 1'b1;
      4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6: return s[int'(c) - 1];
      default: return s[int'(c) - 2];
    endcase
  endfunction

  function automatic logic m_alu(input logic [3:0] c, input logic i);
    return (c == 4'd0 && i == 1'b0) || (c == 4'd7 && i == 1'b1);
  endfunction

  task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%03h expected=%03h", tag, act, exp);
    end
  endtask

  // Drive one microword at a falling edge, clock it, then check at the next falling edge.
  task automatic cyc(input logic r, input logic [3:0] c, input logic i,
                     input logic [11:0] t, input logic [2:0] b, input logic [13:0] s,
                     input string tag);
    logic tk;
    rst = r; mw_cond = c; mw_inv = i; mw_target = t; mw_bsrc = b; status = s;
    tk = m_cond(c, s) ^ i;
    if (r) begin
      e_pc = 12'h000; e_drr = 1'b0;
    end else begin
      e_pc  = tk ? t : e_pc + 12'h001;
      e_drr = m_alu(c, i) && (b == 3'd3);
    end
    @(posedge clk);
    @(negedge clk);
    if (r) begin
      check("R1 uaddr", uaddr, e_pc);
      check("R1 drr", {11'd0, uart_drr}, {11'd0, e_drr});
    end else begin
      check(tk ? {tag, " R3 R4 taken"} : {tag, " R2 R4 step"}, uaddr, e_pc);
      check(e_drr ? {tag, " R6 drr"} : {tag, " R7 drr"}, {11'd0, uart_drr}, {11'd0, e_drr});
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int unsigned seed = 32'd2024;
    void'($urandom(seed));
    e_pc = 12'h000; e_drr = 1'b0;
    @(negedge clk);
    cyc(1, 4'd0, 0, 12'h0, 3'd0, 14'h0, "R1");
    cyc(1, 4'd7, 1, 12'h5A5, 3'd3, 14'h3FFF, "R1");
    // R2 step from reset
    cyc(0, 4'd0, 0, 12'hABC, 3'd1, 14'h3FFF, "R2");
    // R3 branch to 0FE, then carry across slices (R2)
    cyc(0, 4'd7, 0, 12'h0FE, 3'd0, 14'h0, "R3 R8 always");
    cyc(0, 4'd0, 0, 12'h123, 3'd3, 14'h0, "R2 R6");
    cyc(0, 4'd7, 1, 12'h456, 3'd3, 14'h0, "R2 R5 R6");
    // R8 inverted never always branches; wrap FFF->000 (R2)
    cyc(0, 4'd0, 1, 12'hFFE, 3'd3, 14'h0, "R8 R7");
    cyc(0, 4'd0, 0, 12'h000, 3'd2, 14'h0, "R2");
    cyc(0, 4'd0, 0, 12'h000, 3'd3, 14'h0, "R2 wrap R6");
    // R8 branch-if-nonzero
    cyc(0, 4'd1, 1, 12'h321, 3'd3, 14'h0, "R8 nz taken");
    cyc(0, 4'd1, 1, 12'h777, 3'd3, 14'h1, "R8 nz not");
    cyc(0, 4'd1, 0, 12'h0AA, 3'd0, 14'h1, "R4 zero");
    // R4 high codes pick shifted status
    cyc(0, 4'd8, 0, 12'h800, 3'd0, 14'h0040, "R4 code8");
    cyc(0, 4'd15, 0, 12'hF00, 3'd0, 14'h1FFF, "R4 code15");
    // Random mix
    for (int k = 0; k < 4000; k++) begin
      logic [3:0] c;
      logic [2:0] b;
      c = 4'($urandom_range(0, 15));
      if ($urandom_range(0, 3) == 0) c = ($urandom_range(0, 1) == 1) ? 4'd0 : 4'd7;
      b = ($urandom_range(0, 1) == 1) ? 3'd3 : 3'($urandom_range(0, 7));
      cyc($urandom_range(0, 99) == 0, c, 1'($urandom_range(0, 1)),
          12'($urandom), b, 14'($urandom), "rand");
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule